// File: doc/BRIEF.md
# Nested Vectored Exception Arbiter

This block sits beside the fetch stage of a small 32-bit pipelined core and decides which exception the core serves next. Three external interrupt lines (serial receive, serial peripheral, analog converter) and three internal trap lines (system call, illegal opcode, signed overflow) feed it. Each cycle it picks one winner. It tells the core to jump to that source's handler, and it saves the program counter that was interrupted.

Requests are captured in sticky pending bits, so a request that loses is never dropped. A running handler is interrupted only by a request of strictly higher priority. Each level of nesting pushes the saved program counter and the previous active priority onto a small stack, and a return strobe pops that stack. The priority of each external source can be changed through a small synchronous register port. Status and the saved program counter can be read through the same port.

Top module: `vnic_top`

## Requirements
- R1: After reset, redirect_o is 0, active_vec_o is 0, and the level, status and saved-PC registers all read 0.
- R2: Any external request wins over any trap, both when they arrive in the same cycle and when a trap handler is running.
- R3: Vectors are fixed: irq_in[0]=2, irq_in[1]=3, irq_in[2]=4, trap_in[0]=8, trap_in[1]=9, trap_in[2]=10. With equal levels, the lower vector wins.
- R4: Register address 0 holds the levels: bits [1:0] for vector 2, bits [3:2] for vector 3 and bits [5:4] for vector 4. Among external requests the higher level wins, and ties fall back to R3.
- R5: An accepted request makes redirect_o high for one cycle, on the clock after it is accepted, with redirect_pc_o = VEC_BASE + (vector << VEC_SHIFT). The value of pc_in at the accepting edge is saved.
- R6: A pending request preempts the running handler only when its priority is strictly higher. Nesting goes up to DEPTH levels.
- R7: A request that is not accepted stays pending and is served once every handler of higher priority has returned.
- R8: eret_in with at least one level active redirects to the most recently saved PC and restores the previous active vector. No request is accepted in that cycle.
- R9: Address 1 reads the active vector in bits [3:0] and the pending bits in [13:8], where bit 8+i is source i (irq_in[0..2], then trap_in[0..2]). Address 2 reads the top saved PC. Reads return data one clock after the address is presented.
- R10: eret_in while no handler is active causes no redirect and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| irq_in | input | 3 | External interrupt requests |
| trap_in | input | 3 | Internal trap requests |
| pc_in | input | 32 | Program counter of the instruction being interrupted |
| eret_in | input | 1 | Return-from-exception strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 6 | Register write data (levels) |
| reg_rdata | output | 32 | Registered read data |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Fetch redirect target |
| active_vec_o | output | 4 | Vector of the handler now running, 0 when idle |

## Verification
The bench fires all three external lines together with a trap. A design that ranked traps by vector alone, or that forgot losers, would then serve the wrong order or lose a request. It builds a three-deep nest that contains a system-call trap arriving under a higher handler. A design that lets it preempt too early, or drops it, breaks the order of redirects, and a wrong stack pop restores the wrong PC. It raises one source's level so that it overtakes a lower vector, and it strobes a return while idle, where a careless pop would emit a stray redirect.

// File: rtl/vnic_pkg.sv
package vnic_pkg;
  localparam int NSRC   = 6;
  localparam int NEXT   = 3;
  localparam int LVL_W  = 2;
  localparam int VEC_W  = 4;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int KEY_W  = 1 + LVL_W + VEC_W;
  localparam int LVLS_W = NEXT * LVL_W;

  typedef logic [KEY_W-1:0] key_t;

  // source index -> vector number
  function automatic logic [VEC_W-1:0] src_vec(input int unsigned idx);
    case (idx)
      0:       src_vec = VEC_W'(2);
      1:       src_vec = VEC_W'(3);
      2:       src_vec = VEC_W'(4);
      3:       src_vec = VEC_W'(8);
      4:       src_vec = VEC_W'(9);
      default: src_vec = VEC_W'(10);
    endcase
  endfunction
endpackage

// File: rtl/vnic_arbiter.sv
module vnic_arbiter
  import vnic_pkg::*;
(
  input  logic [NSRC-1:0]   cand,
  input  logic [LVLS_W-1:0] levels,
  output logic              win_valid,
  output logic [IDX_W-1:0]  win_idx,
  output key_t              win_key,
  output logic [VEC_W-1:0]  win_vec
);
  key_t key [NSRC];

  // key = {external, level, inverted vector}; larger key wins
  for (genvar g = 0; g < NSRC; g++) begin : g_key
    if (g < NEXT) begin : g_ext
      assign key[g] = {1'b1, levels[g*LVL_W +: LVL_W],
                       VEC_W'(VEC_W'(15) - src_vec(g))};
    end else begin : g_trap
      assign key[g] = {1'b0, {LVL_W{1'b0}},
                       VEC_W'(VEC_W'(15) - src_vec(g))};
    end
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_key   = '0;
    win_vec   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (key[i] > win_key)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_key   = key[i];
        win_vec   = src_vec(i);
      end
    end
  end
endmodule

// File: rtl/vnic_stack.sv
module vnic_stack #(
  parameter int DEPTH = 6,
  parameter int W     = 43,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [W-1:0]  mem_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign cnt   = cnt_q;

  always_comb begin
    mem_d = mem_q;
    cnt_d = cnt_q;
    if (push && !full) begin
      for (int i = 0; i < DEPTH; i++)
        if (cnt_q == CW'(i)) mem_d[i] = din;
      cnt_d = cnt_q + CW'(1);
    end else if (pop && !empty) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < DEPTH; i++)
      if (cnt_q == CW'(i + 1)) dout = mem_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end
endmodule

// File: rtl/vnic_regs.sv
module vnic_regs
  import vnic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [LVLS_W-1:0] wdata,
  input  logic [31:0]       status,
  input  logic [31:0]       epc,
  output logic [LVLS_W-1:0] levels,
  output logic [31:0]       rdata
);
  logic [LVLS_W-1:0] lvl_q, lvl_d;
  logic [31:0]       rd_q, rd_d;

  assign levels = lvl_q;
  assign rdata  = rd_q;

  always_comb begin
    lvl_d = (wr && addr == 2'd0) ? wdata : lvl_q;
    case (addr)
      2'd0:    rd_d = {{(32-LVLS_W){1'b0}}, lvl_q};
      2'd1:    rd_d = status;
      2'd2:    rd_d = epc;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      rd_q  <= '0;
    end else begin
      lvl_q <= lvl_d;
      rd_q  <= rd_d;
    end
  end
endmodule

// File: rtl/vnic_top.sv
module vnic_top
  import vnic_pkg::*;
#(
  parameter int          DEPTH     = 6,
  parameter logic [31:0] VEC_BASE  = 32'h8000_0000,
  parameter int          VEC_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEXT-1:0]   irq_in,
  input  logic [NSRC-NEXT-1:0] trap_in,
  input  logic [31:0]       pc_in,
  input  logic              eret_in,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [LVLS_W-1:0] reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              redirect_o,
  output logic [31:0]       redirect_pc_o,
  output logic [VEC_W-1:0]  active_vec_o
);
  localparam int SW = 32 + KEY_W + VEC_W;
  localparam int CW = $clog2(DEPTH + 1);

  logic [NSRC-1:0]   pend_q, pend_d, cand, acc_mask;
  key_t              cur_key_q, cur_key_d;
  logic [VEC_W-1:0]  cur_vec_q, cur_vec_d;
  logic              redir_q, redir_d;
  logic [31:0]       redir_pc_q, redir_pc_d;
  logic [LVLS_W-1:0] levels;
  logic              win_valid;
  logic [IDX_W-1:0]  win_idx;
  key_t              win_key;
  logic [VEC_W-1:0]  win_vec;
  logic              accept, do_pop, full, empty;
  logic [SW-1:0]     top_ent;
  logic [31:0]       top_pc;
  key_t              top_key;
  logic [VEC_W-1:0]  top_vec;
  logic [CW-1:0]     depth;
  logic [31:0]       status;

  assign cand = pend_q | {trap_in, irq_in};

  vnic_arbiter arb_i (
    .cand(cand), .levels(levels), .win_valid(win_valid),
    .win_idx(win_idx), .win_key(win_key), .win_vec(win_vec)
  );

  assign do_pop = eret_in && !empty;
  assign accept = win_valid && (win_key > cur_key_q) && !full && !eret_in;
  assign acc_mask = accept ? (NSRC'(1) << win_idx) : '0;

  vnic_stack #(.DEPTH(DEPTH), .W(SW)) stk_i (
    .clk(clk), .rst_n(rst_n), .push(accept), .pop(do_pop),
    .din({pc_in, cur_key_q, cur_vec_q}), .dout(top_ent),
    .cnt(depth), .full(full), .empty(empty)
  );
  assign {top_pc, top_key, top_vec} = top_ent;

  assign status = {{(32-8-NSRC){1'b0}}, pend_q, {(8-VEC_W){1'b0}}, cur_vec_q};

  vnic_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .status(status), .epc(top_pc),
    .levels(levels), .rdata(reg_rdata)
  );

  always_comb begin
    pend_d     = cand & ~acc_mask;
    cur_key_d  = cur_key_q;
    cur_vec_d  = cur_vec_q;
    redir_d    = 1'b0;
    redir_pc_d = redir_pc_q;
    if (accept) begin
      cur_key_d  = win_key;
      cur_vec_d  = win_vec;
      redir_d    = 1'b1;
      redir_pc_d = VEC_BASE + ({{(32-VEC_W){1'b0}}, win_vec} << VEC_SHIFT);
    end else if (do_pop) begin
      cur_key_d  = top_key;
      cur_vec_d  = top_vec;
      redir_d    = 1'b1;
      redir_pc_d = top_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      cur_key_q  <= '0;
      cur_vec_q  <= '0;
      redir_q    <= 1'b0;
      redir_pc_q <= '0;
    end else begin
      pend_q     <= pend_d;
      cur_key_q  <= cur_key_d;
      cur_vec_q  <= cur_vec_d;
      redir_q    <= redir_d;
      redir_pc_q <= redir_pc_d;
    end
  end

  assign redirect_o    = redir_q;
  assign redirect_pc_o = redir_pc_q;
  assign active_vec_o  = cur_vec_q;
endmodule

// File: rtl/vnic_checker.sv
module vnic_checker
  import vnic_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            eret_in,
  input logic [31:0]     pc_in,
  input logic            redirect_o,
  input logic [31:0]     redirect_pc_o,
  input logic [CW-1:0]   depth,
  input logic [31:0]     top_pc,
  input logic            accept,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] acc_mask,
  input logic [NSRC-1:0] cand,
  input logic            win_valid,
  input logic [IDX_W-1:0] win_idx
);
  a_r2_ext_beats_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && |cand[NEXT-1:0]) |-> (win_idx < IDX_W'(NEXT)));

  a_r5_pc_saved: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (redirect_o && top_pc == $past(pc_in)));

  a_r6_depth_limit: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(DEPTH));

  a_r7_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~acc_mask)) == $past(pend_q & ~acc_mask)));

  a_r8_return_target: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_in && depth != '0) |=> (redirect_o && redirect_pc_o == $past(top_pc)));

  a_r10_idle_return: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_in && depth == '0) |=> !redirect_o);
endmodule

bind vnic_top vnic_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .eret_in(eret_in), .pc_in(pc_in),
  .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
  .depth(depth), .top_pc(top_pc), .accept(accept), .pend_q(pend_q),
  .acc_mask(acc_mask), .cand(cand), .win_valid(win_valid), .win_idx(win_idx)
);

// File: tb/vnic_top_tb_top.sv
`timescale 1ns/1ps
module vnic_top_tb_top;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  irq_in = '0;
  logic [2:0]  trap_in = '0;
  logic [31:0] pc_in = '0;
  logic        eret_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [5:0]  reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        redirect_o;
  logic [31:0] redirect_pc_o;
  logic [3:0]  active_vec_o;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  vnic_top dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trap_in(trap_in),
    .pc_in(pc_in), .eret_in(eret_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o), .active_vec_o(active_vec_o)
  );

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tgt(int vec);
    return BASE + (32'(vec) << 4);
  endfunction

  task automatic expect_redir(string tag, logic [31:0] pc);
    exp_q.push_back(pc);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && redirect_o) begin
      if (exp_q.size() == 0) begin
        check_eq("R10 unexpected redirect", redirect_pc_o, 32'hFFFF_FFFF);
      end else begin
        check_eq(tag_q.pop_front(), redirect_pc_o, exp_q.pop_front());
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    check_eq(tag, reg_rdata, exp);
  endtask

  task automatic wr(logic [5:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(logic [2:0] irq, logic [2:0] trap);
    @(negedge clk);
    irq_in = irq; trap_in = trap;
    @(negedge clk);
    irq_in = '0; trap_in = '0;
  endtask

  task automatic ret();
    @(negedge clk);
    eret_in = 1'b1;
    @(negedge clk);
    eret_in = 1'b0;
    idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check_eq("R1 redirect", {31'b0, redirect_o}, 32'h0);
    check_eq("R1 active vector", {28'b0, active_vec_o}, 32'h0);
    rd(2'd0, 32'h0, "R1 levels");
    rd(2'd1, 32'h0, "R1 status");
    rd(2'd2, 32'h0, "R1 epc");

    // Phase A: all three externals plus overflow trap together (R2, R3)
    pc_in = 32'h100;
    expect_redir("R3 first is vector 2", tgt(2));
    pulse(3'b111, 3'b100);
    idle(2);
    rd(2'd1, 32'h0000_2602, "R9 status vec2 with pending");
    rd(2'd2, 32'h100, "R5 saved pc");
    expect_redir("R8 return A1", 32'h100);
    expect_redir("R3 second is vector 3", tgt(3));
    ret();
    expect_redir("R8 return A2", 32'h100);
    expect_redir("R3 third is vector 4", tgt(4));
    ret();
    expect_redir("R8 return A3", 32'h100);
    expect_redir("R2 trap served after externals", tgt(10));
    ret();
    expect_redir("R8 return A4", 32'h100);
    ret();
    check_eq("R8 idle after returns", {28'b0, active_vec_o}, 32'h0);

    // Phase B: nesting (R2, R6, R7, R8)
    pc_in = 32'h200;
    expect_redir("R5 overflow trap", tgt(10));
    pulse(3'b000, 3'b100);
    idle(2);
    pc_in = 32'h300;
    expect_redir("R2 external preempts trap", tgt(4));
    pulse(3'b100, 3'b000);
    idle(2);
    pc_in = 32'h400;
    pulse(3'b000, 3'b001);
    idle(2);
    check_eq("R7 syscall waits under vector 4", {28'b0, active_vec_o}, 32'h4);
    pc_in = 32'h500;
    expect_redir("R6 vector 3 preempts vector 4", tgt(3));
    pulse(3'b010, 3'b000);
    idle(2);
    rd(2'd1, 32'h0000_0803, "R9 status vec3 syscall pending");
    rd(2'd2, 32'h500, "R9 epc top");
    expect_redir("R8 return to 0x500", 32'h500);
    ret();
    check_eq("R8 previous vector restored", {28'b0, active_vec_o}, 32'h4);
    pc_in = 32'h400;
    expect_redir("R8 return to 0x300", 32'h300);
    expect_redir("R7 syscall served later", tgt(8));
    ret();
    check_eq("R6 syscall nested over overflow", {28'b0, active_vec_o}, 32'h8);
    expect_redir("R8 return to 0x400", 32'h400);
    ret();
    check_eq("R8 back in overflow handler", {28'b0, active_vec_o}, 32'hA);
    expect_redir("R8 return to 0x200", 32'h200);
    ret();

    // Phase C: programmed levels (R4)
    wr(6'h30);
    rd(2'd0, 32'h30, "R4 level readback");
    pc_in = 32'h600;
    expect_redir("R4 raised vector 4 wins", tgt(4));
    pulse(3'b110, 3'b010);
    idle(2);
    pulse(3'b001, 3'b000);
    idle(2);
    check_eq("R4 vector 2 waits under level 3", {28'b0, active_vec_o}, 32'h4);
    expect_redir("R8 return C1", 32'h600);
    expect_redir("R4 tie falls back to vector 2", tgt(2));
    ret();
    expect_redir("R8 return C2", 32'h600);
    expect_redir("R4 then vector 3", tgt(3));
    ret();
    expect_redir("R8 return C3", 32'h600);
    expect_redir("R3 illegal opcode trap", tgt(9));
    ret();
    expect_redir("R8 return C4", 32'h600);
    ret();

    // Phase D: return while idle (R10)
    ret();
    check_eq("R10 vector after idle return", {28'b0, active_vec_o}, 32'h0);
    rd(2'd1, 32'h0, "R10 status unchanged");
    check_eq("R5 all redirects seen", 32'(exp_q.size()), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule